// File: doc/BRIEF.md
# Upstream-Down Packet Disposition Filter

This block sits in the packet path of one switch partition and decides, for each transaction-layer packet, what happens to it while the partition has no upstream port. The isolation mode is on only when two conditions hold together: software has masked the reset that a lost upstream link would normally trigger, and the upstream data link is down. While the mode is on, the partition keeps serving its downstream ports. Traffic from one downstream port to another still flows. Packets with no downstream destination are answered as unsupported requests. Packets that the switch generates for the root, such as legacy interrupt messages, are discarded without any error.

A routing stage upstream of the filter sends one descriptor per packet. The descriptor carries the destination class, the destination downstream port index, whether the switch generated the packet itself, and whether the packet is headed for the root. The filter returns one registered decision per descriptor. That decision is one-hot: forward, unsupported request or silent drop. The filter also drives one flag per downstream port that ties the port's low-power link-state decisions to the upstream port. The flag is released while the mode is on.

The mode never changes while a packet is in flight. The filter tracks the packet from its descriptor to its end marker and samples the mode inputs only in idle cycles.

Top module: `pdf_upstream_down_filter`

## Requirements
- R1: Isolation mode is active exactly when `lnk_rst_mask` is 1 and `up_link_up` is 0. Every other combination gives normal mode.
- R2: In normal mode every decision is forward (`dec` = 3'b001), whatever the descriptor holds.
- R3: In isolation mode, a descriptor is forwarded when its destination class is 2'b00 (downstream port) and its port index is below `NUM_DSP`, unless R5 applies.
- R4: In isolation mode, a descriptor whose class is not 2'b00, or whose port index is `NUM_DSP` or more, gets unsupported request (`dec` = 3'b010), unless R5 applies.
- R5: In isolation mode, a descriptor with both `desc_internal` = 1 and `desc_root_bound` = 1 is dropped silently (`dec` = 3'b100). This takes priority over R3 and R4.
- R6: Each bit of `pwr_tie` is 1 in normal mode and 0 in isolation mode. A 0 means that the port's L0s and L1 entry and exit may ignore the upstream port.
- R7: `dec_valid` is 1 in the cycle after a cycle with `desc_valid` = 1, and 0 otherwise. While `dec_valid` is 1, `dec` has exactly one bit set: bit 0 forward, bit 1 unsupported request, bit 2 drop. While `dec_valid` is 0, `dec` is 3'b000.
- R8: A packet is in flight from its `desc_valid` cycle through its `pkt_end` cycle. A single-cycle packet asserts both signals together. The effective mode changes only at a clock edge whose preceding cycle had no packet in flight and no `desc_valid`. A descriptor that arrives right after a `pkt_end` therefore still uses the old mode.
- R9: After reset the mode is normal, `dec_valid` is 0, `dec` is 3'b000 and every `pwr_tie` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lnk_rst_mask | input | 1 | Masks the reset that a lost upstream link would trigger |
| up_link_up | input | 1 | Upstream data link is up |
| desc_valid | input | 1 | Descriptor strobe, one per packet |
| desc_class | input | 2 | Destination class: 00 downstream, 01 root, 10 switch function, 11 reserved |
| desc_port | input | PORT_W | Destination downstream port index |
| desc_internal | input | 1 | Packet was generated by the switch |
| desc_root_bound | input | 1 | Packet is routed toward the root |
| pkt_end | input | 1 | Last cycle of the current packet |
| dec_valid | output | 1 | Decision strobe |
| dec | output | 3 | One-hot decision {drop, unsupported, forward} |
| pwr_tie | output | NUM_DSP | Per-port coupling of low-power state to the upstream port |

## Verification
The assertions run on every cycle. They check that each decision is one-hot and arrives exactly one cycle after its descriptor, that an idle output is zero, and that normal mode yields only forward decisions. They also check that the power flags follow the effective mode and that the mode holds steady while a packet is in flight. The assertions cannot show which of the three outcomes a given descriptor must receive. The bench's sweep of every mode input combined with every descriptor field shows that, including out-of-range port indices and the drop priority. Only the directed multi-cycle packet scenarios show that the mode waits for packet boundaries, including the back-to-back case after a packet end.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

  typedef enum logic [1:0] {
    DST_DSP  = 2'b00,
    DST_ROOT = 2'b01,
    DST_FUNC = 2'b10,
    DST_RSVD = 2'b11
  } dst_class_e;

  localparam int DEC_W    = 3;
  localparam int BIT_FWD  = 0;
  localparam int BIT_UR   = 1;
  localparam int BIT_DROP = 2;

  localparam logic [DEC_W-1:0] DEC_FWD  = 3'b001;
  localparam logic [DEC_W-1:0] DEC_UR   = 3'b010;
  localparam logic [DEC_W-1:0] DEC_DROP = 3'b100;
  localparam logic [DEC_W-1:0] DEC_NONE = 3'b000;

  function automatic logic iso_condition(input logic mask, input logic link_up);
    return mask & ~link_up;
  endfunction

  function automatic logic is_peer(input logic [1:0] cls, input logic port_ok);
    return (cls == DST_DSP) && port_ok;
  endfunction

  function automatic logic is_silent(input logic internal, input logic root_bound);
    return internal & root_bound;
  endfunction

  function automatic logic [DEC_W-1:0] disposition(
    input logic       iso,
    input logic [1:0] cls,
    input logic       port_ok,
    input logic       internal,
    input logic       root_bound
  );
    logic [DEC_W-1:0] r;
    if (!iso)                               r = DEC_FWD;
    else if (is_silent(internal, root_bound)) r = DEC_DROP;
    else if (is_peer(cls, port_ok))         r = DEC_FWD;
    else                                    r = DEC_UR;
    return r;
  endfunction

  function automatic logic in_flight_next(
    input logic busy, input logic start, input logic stop
  );
    return start ? ~stop : (busy & ~stop);
  endfunction

endpackage

// File: rtl/pdf_mode_gate.sv
module pdf_mode_gate
  import pdf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lnk_rst_mask,
  input  logic up_link_up,
  input  logic desc_valid,
  input  logic pkt_end,
  output logic iso_mode,
  output logic in_pkt,
  output logic mode_upd
);
  logic iso_raw;
  logic iso_q;
  logic busy_q;

  assign iso_raw  = iso_condition(lnk_rst_mask, up_link_up);
  assign mode_upd = ~busy_q & ~desc_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      iso_q  <= 1'b0;
    end else begin
      busy_q <= in_flight_next(busy_q, desc_valid, pkt_end);
      if (mode_upd) iso_q <= iso_raw;
    end
  end

  assign iso_mode = iso_q;
  assign in_pkt   = busy_q;
endmodule

// File: rtl/pdf_classify.sv
module pdf_classify
  import pdf_pkg::*;
#(
  parameter int NUM_DSP = 6,
  parameter int PORT_W  = 3
) (
  input  logic              iso_mode,
  input  logic [1:0]        cls,
  input  logic [PORT_W-1:0] port,
  input  logic              internal,
  input  logic              root_bound,
  output logic              port_ok,
  output logic [DEC_W-1:0]  verdict
);
  localparam int CMP_W = PORT_W + 1;
  localparam logic [CMP_W-1:0] PORT_LIM = CMP_W'(NUM_DSP);

  assign port_ok = ({1'b0, port} < PORT_LIM);
  assign verdict = disposition(iso_mode, cls, port_ok, internal, root_bound);
endmodule

// File: rtl/pdf_dec_reg.sv
module pdf_dec_reg
  import pdf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [DEC_W-1:0] verdict,
  output logic             dec_valid,
  output logic [DEC_W-1:0] dec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec       <= DEC_NONE;
    end else begin
      dec_valid <= take;
      dec       <= take ? verdict : DEC_NONE;
    end
  end
endmodule

// File: rtl/pdf_pwr_couple.sv
module pdf_pwr_couple #(
  parameter int NUM_DSP = 6
) (
  input  logic               iso_mode,
  output logic [NUM_DSP-1:0] pwr_tie
);
  for (genvar p = 0; p < NUM_DSP; p++) begin : g_port
    assign pwr_tie[p] = ~iso_mode;
  end
endmodule

// File: rtl/pdf_upstream_down_filter.sv
module pdf_upstream_down_filter
  import pdf_pkg::*;
#(
  parameter int NUM_DSP = 6,
  parameter int PORT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lnk_rst_mask,
  input  logic               up_link_up,
  input  logic               desc_valid,
  input  logic [1:0]         desc_class,
  input  logic [PORT_W-1:0]  desc_port,
  input  logic               desc_internal,
  input  logic               desc_root_bound,
  input  logic               pkt_end,
  output logic               dec_valid,
  output logic [2:0]         dec,
  output logic [NUM_DSP-1:0] pwr_tie
);
  logic             iso_mode;
  logic             in_pkt;
  logic             mode_upd;
  logic             port_ok;
  logic [DEC_W-1:0] verdict;

  pdf_mode_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .lnk_rst_mask (lnk_rst_mask),
    .up_link_up   (up_link_up),
    .desc_valid   (desc_valid),
    .pkt_end      (pkt_end),
    .iso_mode     (iso_mode),
    .in_pkt       (in_pkt),
    .mode_upd     (mode_upd)
  );

  pdf_classify #(.NUM_DSP(NUM_DSP), .PORT_W(PORT_W)) u_cls (
    .iso_mode   (iso_mode),
    .cls        (desc_class),
    .port       (desc_port),
    .internal   (desc_internal),
    .root_bound (desc_root_bound),
    .port_ok    (port_ok),
    .verdict    (verdict)
  );

  pdf_dec_reg u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (desc_valid),
    .verdict   (verdict),
    .dec_valid (dec_valid),
    .dec       (dec)
  );

  pdf_pwr_couple #(.NUM_DSP(NUM_DSP)) u_pwr (
    .iso_mode (iso_mode),
    .pwr_tie  (pwr_tie)
  );
endmodule

// File: rtl/pdf_upstream_down_filter_chk.sv
module pdf_upstream_down_filter_chk #(
  parameter int NUM_DSP = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               desc_valid,
  input logic               dec_valid,
  input logic [2:0]         dec,
  input logic [NUM_DSP-1:0] pwr_tie,
  input logic               iso_mode,
  input logic               in_pkt
);
  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones(dec) == 1)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (dec == 3'b000)); // R7
  AST_DEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> dec_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_valid |=> !dec_valid); // R7
  AST_NORMAL_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !iso_mode) |-> (dec == 3'b001)); // R2
  AST_PWR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_tie == {NUM_DSP{!iso_mode}}); // R6
  AST_MODE_HOLD_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt |=> $stable(iso_mode)); // R8
  AST_MODE_HOLD_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> $stable(iso_mode)); // R8
endmodule

bind pdf_upstream_down_filter pdf_upstream_down_filter_chk #(.NUM_DSP(NUM_DSP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desc_valid (desc_valid),
  .dec_valid  (dec_valid),
  .dec        (dec),
  .pwr_tie    (pwr_tie),
  .iso_mode   (iso_mode),
  .in_pkt     (in_pkt)
);

// File: tb/pdf_upstream_down_filter_tb_top.sv
module pdf_upstream_down_filter_tb_top;
  localparam int NUM_DSP = 6;
  localparam int PORT_W  = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               lnk_rst_mask = 1'b0;
  logic               up_link_up = 1'b1;
  logic               desc_valid = 1'b0;
  logic [1:0]         desc_class = 2'b00;
  logic [PORT_W-1:0]  desc_port = '0;
  logic               desc_internal = 1'b0;
  logic               desc_root_bound = 1'b0;
  logic               pkt_end = 1'b0;
  logic               dec_valid;
  logic [2:0]         dec;
  logic [NUM_DSP-1:0] pwr_tie;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pdf_upstream_down_filter #(.NUM_DSP(NUM_DSP), .PORT_W(PORT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lnk_rst_mask(lnk_rst_mask), .up_link_up(up_link_up),
    .desc_valid(desc_valid), .desc_class(desc_class), .desc_port(desc_port),
    .desc_internal(desc_internal), .desc_root_bound(desc_root_bound),
    .pkt_end(pkt_end), .dec_valid(dec_valid), .dec(dec), .pwr_tie(pwr_tie)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outcome: weight 1 forward, 2 unsupported, 4 drop.
  function automatic logic [2:0] expect_dec(input logic iso, input logic [1:0] c,
                                            input int p, input logic i, input logic r);
    int w;
    if (iso == 1'b0) w = 1;
    else if ((i && r) == 1'b1) w = 4;
    else if (c == 2'd0 && p < NUM_DSP) w = 1;
    else w = 2;
    return w[2:0];
  endfunction

  task automatic idle_cycle();
    desc_valid = 1'b0; pkt_end = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 dec_valid", {31'b0, dec_valid}, 0);
    chk("R9 dec", {29'b0, dec}, 0);
    chk("R9 pwr_tie", {26'b0, pwr_tie}, 32'h3f);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R7 sweep
    for (int m = 0; m < 4; m++) begin
      logic iso;
      lnk_rst_mask = m[1]; up_link_up = m[0];
      iso = (m == 2);
      idle_cycle();
      chk(iso ? "R6 pwr_tie iso" : "R1 R6 pwr_tie normal", {26'b0, pwr_tie},
          iso ? 32'h0 : 32'h3f);
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 8; p++)
          for (int b = 0; b < 4; b++) begin
            logic [2:0] e;
            desc_valid = 1'b1; pkt_end = 1'b1;
            desc_class = c[1:0]; desc_port = p[2:0];
            desc_internal = b[1]; desc_root_bound = b[0];
            e = expect_dec(iso, c[1:0], p, b[1], b[0]);
            @(negedge clk);
            desc_valid = 1'b0; pkt_end = 1'b0;
            chk("R7 dec_valid", {31'b0, dec_valid}, 1);
            if (!iso) chk("R2 normal forward", {29'b0, dec}, {29'b0, e});
            else if (e == 3'b100) chk("R5 silent drop", {29'b0, dec}, {29'b0, e});
            else if (e == 3'b001) chk("R3 peer forward", {29'b0, dec}, {29'b0, e});
            else chk("R4 unsupported", {29'b0, dec}, {29'b0, e});
          end
      @(negedge clk);
      chk("R7 idle dec_valid", {31'b0, dec_valid}, 0);
      chk("R7 idle dec", {29'b0, dec}, 0);
    end

    // R8: mode frozen during a multi-cycle packet
    lnk_rst_mask = 1'b0; up_link_up = 1'b1;
    idle_cycle(); idle_cycle();
    desc_valid = 1'b1; desc_class = 2'b01; desc_port = 0;
    desc_internal = 1'b0; desc_root_bound = 1'b0;
    @(negedge clk);
    desc_valid = 1'b0;
    chk("R8 first decision forward", {29'b0, dec}, 1);
    lnk_rst_mask = 1'b1; up_link_up = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 held mid-packet", {26'b0, pwr_tie}, 32'h3f);
    end
    pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
    chk("R8 held at end edge", {26'b0, pwr_tie}, 32'h3f);
    // back-to-back descriptor right after pkt_end uses old mode
    desc_valid = 1'b1; pkt_end = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0; pkt_end = 1'b0;
    chk("R8 back-to-back old mode", {29'b0, dec}, 1);
    chk("R8 still normal", {26'b0, pwr_tie}, 32'h3f);
    @(negedge clk);
    chk("R8 mode applied after idle", {26'b0, pwr_tie}, 32'h0);
    desc_valid = 1'b1; pkt_end = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0; pkt_end = 1'b0;
    chk("R8 R4 new mode decision", {29'b0, dec}, 2);

    // R8: leaving isolation also waits for the packet end
    desc_valid = 1'b1; desc_class = 2'b00; desc_port = 3'd7;
    @(negedge clk);
    desc_valid = 1'b0;
    chk("R4 out-of-range port", {29'b0, dec}, 2);
    lnk_rst_mask = 1'b0;
    @(negedge clk);
    chk("R8 exit held", {26'b0, pwr_tie}, 32'h0);
    pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
    @(negedge clk);
    chk("R1 R8 exit applied", {26'b0, pwr_tie}, 32'h3f);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule